// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block turns a one-bit NRZ stream, sampled on every rising edge of a bit-rate clock, into parallel words of `WORD_W` bits (four by default). The bit that arrives first in a word lands on the lowest output bit. A free-running counter of `2*WORD_W` states sets the word boundary. The same counter drives two single-cycle clock-enable outputs: one at a quarter of the bit rate and one at an eighth of it. Logic running at the word rate can use these enables in place of derived clocks.

Two serial inputs are provided. A select line picks the one that is shifted in, so the second input can carry a loopback path during test. A slip request, which may arrive with no relation to the clock, is passed through a synchronizer and an edge detector. Each new request makes the counter skip exactly one count. This moves the word boundary one bit later, so the bit that used to sit on output bit 1 now sits on output bit 0. Repeated requests let a receiver hunt for frame alignment.

A wide-mode input makes the parallel output load only once per eight bit clocks, so two instances can be combined into an eight-bit converter. A synchronous reset returns the counter and all registers to zero, which lets several instances start in lockstep.

Top module: `bitslip_deser`

## Requirements
- R1: While `rst` is high at a rising edge, `word_q`, `word_vld`, `div4_en` and `div8_en` are 0 after that edge. The first bit sampled after `rst` falls becomes `word_q[0]` of the first word.
- R2: In each word, the k-th bit received (k = 0 first) appears on `word_q[k]`.
- R3: With `loop_sel` = 0 the bit on `ser_a` is shifted in, and with `loop_sel` = 1 the bit on `ser_b` is shifted in. The unselected input has no effect on `word_q`.
- R4: Counting the first edge after reset as edge 0, `div4_en` is high for exactly one cycle after edges 3, 7, 11 and so on, and low in every other cycle.
- R5: `div8_en` is high for one cycle after edges 7, 15, 23 and so on. Each `div8_en` pulse coincides with a `div4_en` pulse.
- R6: With `mode8` = 0, `word_q` loads and `word_vld` pulses in exactly the cycles in which `div4_en` is high.
- R7: With `mode8` = 1, `word_q` loads and `word_vld` pulses only together with `div8_en`. The loaded word holds the last four bits of the eight-bit frame, bit 4 of the frame on `word_q[0]`.
- R8: `word_q` does not change in any cycle in which `word_vld` is low.
- R9: A rising edge on `slip_req` that is held for at least two clocks makes the counter hold its value at the third rising edge after the rise. Every later boundary and enable pulse is delayed by one bit clock. For a stream whose words were `0001`, the words become `1000`.
- R10: A `slip_req` held high causes exactly one slip. A further slip needs `slip_req` to return low and rise again.
- R11: If the held count falls on a boundary edge, no `div4_en`, `div8_en` or `word_vld` pulse follows that edge. The pulses follow the next edge instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_a | input | 1 | Main serial data input |
| ser_b | input | 1 | Loopback serial data input |
| loop_sel | input | 1 | 0 selects `ser_a`, 1 selects `ser_b` |
| mode8 | input | 1 | 0: load every 4 bits; 1: load every 8 bits |
| slip_req | input | 1 | Asynchronous request to slip the boundary by one bit |
| word_q | output | WORD_W | Parallel word, first received bit in bit 0 |
| word_vld | output | 1 | One-cycle strobe when `word_q` loads |
| div4_en | output | 1 | One-cycle enable every 4 bit clocks |
| div8_en | output | 1 | One-cycle enable every 8 bit clocks |

## Verification
The critical overlap is a synchronized slip landing in the same cycle as a word boundary. The counter must then hold instead of wrap, and all strobes must wait one cycle. The bench provokes this by tracking its own count of the boundary phase and raising `slip_req` exactly three edges before a count of 3. It then checks that no `word_vld` or `div4_en` follows that edge and that both follow the next one. A second overlap, a boundary that shares a count with the eight-bit enable while `mode8` is high, is judged by checking that `word_vld` stays low on the intermediate quarter-rate pulse.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_LOOP = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic quarter;
    logic eighth;
  } ticks_t;
endpackage

// File: rtl/bd_slip_sync.sv
module bd_slip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic slip_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("bd_slip_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], req_async};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign slip_pulse = chain_q[STAGES-1] & ~last_q;

  // A held request yields only one pulse.
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> !slip_pulse);
endmodule

// File: rtl/bd_divider.sv
module bd_divider
  import bd_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   slip,
  output ticks_t ticks
);
  localparam int STATES = 2 * WORD_W;
  localparam int CW     = $clog2(STATES);
  localparam logic [CW-1:0] HALF_LAST = CW'(WORD_W - 1);
  localparam logic [CW-1:0] FULL_LAST = CW'(STATES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!slip) begin
      cnt_q <= (cnt_q == FULL_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    ticks.quarter = !slip && ((cnt_q == HALF_LAST) || (cnt_q == FULL_LAST));
    ticks.eighth  = !slip && (cnt_q == FULL_LAST);
  end

  // A slip swallows exactly one count.
  p_slip_holds_r9: assert property (@(posedge clk) disable iff (rst)
    slip |=> cnt_q == $past(cnt_q));
  // The counter wraps after its last state.
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (!slip && cnt_q == FULL_LAST) |=> cnt_q == '0);
endmodule

// File: rtl/bd_shift_capture.sv
module bd_shift_capture
  import bd_pkg::*;
#(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_a,
  input  logic              ser_b,
  input  src_sel_e          src_sel,
  input  logic              take,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld
);
  logic              bit_in;
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_next;

  assign bit_in  = (src_sel == SRC_LOOP) ? ser_b : ser_a;
  // Newest bit enters at the top, so the oldest ends in bit 0.
  assign sr_next = {bit_in, sr_q[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q     <= '0;
      word_q   <= '0;
      word_vld <= 1'b0;
    end else begin
      sr_q     <= sr_next;
      word_vld <= take;
      if (take) word_q <= sr_next;
    end
  end

  p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(word_q));
  p_strobe_follows_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> word_vld);
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser
  import bd_pkg::*;
#(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_a,
  input  logic              ser_b,
  input  logic              loop_sel,
  input  logic              mode8,
  input  logic              slip_req,
  output logic [WORD_W-1:0] word_q,
  output logic              word_vld,
  output logic              div4_en,
  output logic              div8_en
);
  logic     slip;
  ticks_t   ticks;
  logic     take;
  src_sel_e src_sel;

  assign src_sel = src_sel_e'(loop_sel);
  assign take    = mode8 ? ticks.eighth : ticks.quarter;

  bd_slip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .req_async(slip_req), .slip_pulse(slip)
  );

  bd_divider #(.WORD_W(WORD_W)) u_div (
    .clk(clk), .rst(rst), .slip(slip), .ticks(ticks)
  );

  bd_shift_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b),
    .src_sel(src_sel), .take(take), .word_q(word_q), .word_vld(word_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      div4_en <= 1'b0;
      div8_en <= 1'b0;
    end else begin
      div4_en <= ticks.quarter;
      div8_en <= ticks.eighth;
    end
  end

  p_vld_with_div4_r6: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> div4_en);
  p_div8_in_div4_r5: assert property (@(posedge clk) disable iff (rst)
    div8_en |-> div4_en);
  p_div4_gap_r4: assert property (@(posedge clk) disable iff (rst)
    div4_en |=> !div4_en);
  p_no_fire_on_slip_r11: assert property (@(posedge clk) disable iff (rst)
    slip |=> !div4_en && !word_vld);
endmodule

// File: tb/bitslip_deser_bench.sv
`timescale 1ns/1ps
module bitslip_deser_bench;
  localparam int W = 4;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_a = 1'b0, ser_b = 1'b0, loop_sel = 1'b0, mode8 = 1'b0, slip_req = 1'b0;
  logic [W-1:0] word_q;
  logic word_vld, div4_en, div8_en;

  int total = 0, bad = 0;
  // bench-side expectation state
  int m = 0, edge_n = 0, hold_edge = -100, sidx = 0;
  logic [W-1:0] msr = '0, exp_word = '0;
  logic exp_vld = 0, exp_d4 = 0, exp_d8 = 0;

  always #(CLK_P/2) clk = ~clk;

  bitslip_deser #(.WORD_W(W)) u_bitslip_deser (
    .clk(clk), .rst(rst), .ser_a(ser_a), .ser_b(ser_b), .loop_sel(loop_sel),
    .mode8(mode8), .slip_req(slip_req), .word_q(word_q), .word_vld(word_vld),
    .div4_en(div4_en), .div8_en(div8_en)
  );

  // {loop_sel, word bits}; bit 0 is sent first
  localparam logic [4:0] VEC [0:7] = '{
    5'b0_0001, 5'b0_1000, 5'b0_1010, 5'b1_0101,
    5'b1_1100, 5'b0_0011, 5'b1_1111, 5'b0_0110
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m = 0; edge_n = 0; hold_edge = -100; msr = '0; exp_word = '0;
    exp_vld = 0; exp_d4 = 0; exp_d8 = 0;
  endtask

  // called at a negedge: drive one bit, pass one edge, check at next negedge
  task automatic tick(input logic b);
    ser_a = loop_sel ? ~b : b;
    ser_b = loop_sel ? b : ~b;
    @(posedge clk);
    edge_n++;
    if (edge_n == hold_edge) begin
      exp_d4 = 0; exp_d8 = 0; exp_vld = 0;
    end else begin
      exp_d4 = (m == W-1) || (m == 2*W-1);
      exp_d8 = (m == 2*W-1);
      exp_vld = mode8 ? exp_d8 : exp_d4;
      if (exp_vld) exp_word = {b, msr[W-1:1]};
      m = (m + 1) % (2*W);
    end
    msr = {b, msr[W-1:1]};
    @(negedge clk);
    chk("R4", {31'b0, div4_en}, {31'b0, exp_d4});
    chk("R5", {31'b0, div8_en}, {31'b0, exp_d8});
    chk(mode8 ? "R7" : "R6", {31'b0, word_vld}, {31'b0, exp_vld});
    chk(exp_vld ? "R2" : "R8", {28'b0, word_q}, {28'b0, exp_word});
  endtask

  task automatic tick_pat();
    tick(sidx % 4 == 0);
    sidx++;
  endtask

  task automatic do_reset(input logic dirty);
    @(negedge clk);
    rst = 1'b1;
    ser_a = dirty; ser_b = dirty;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", {28'b0, word_q, word_vld, div4_en, div8_en}, 32'h0);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic raise_slip();
    slip_req = 1'b1;
    hold_edge = edge_n + 3;
  endtask

  task automatic until_vld();
    for (int i = 0; i < 16; i++) begin
      tick_pat();
      if (word_vld) break;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    // table walk: R2, R3 (other input carries the complement)
    for (int v = 0; v < 8; v++) begin
      loop_sel = VEC[v][4];
      for (int k = 0; k < W; k++) tick(VEC[v][k]);
      chk(VEC[v][4] ? "R3" : "R2", {28'b0, word_q}, {28'b0, VEC[v][3:0]});
      chk("R6", {31'b0, word_vld}, 32'h1);
    end
    loop_sel = 1'b0;

    // mid-run reset with dirty state, then first bit must land on bit 0 (R1)
    do_reset(1'b1);
    tick(1); tick(0); tick(0); tick(0);
    chk("R1", {28'b0, word_q}, 32'h1);

    // slip tests on period-4 pattern (R9, R10)
    do_reset(1'b0);
    sidx = 0;
    repeat (8) tick_pat();
    chk("R9", {28'b0, word_q}, 32'h1);
    raise_slip();
    repeat (20) tick_pat();     // held high: only one slip
    until_vld();
    chk("R9", {28'b0, word_q}, 32'h8);
    chk("R10", {28'b0, word_q}, 32'h8);
    slip_req = 1'b0;
    repeat (4) tick_pat();
    raise_slip();
    repeat (12) tick_pat();
    until_vld();
    chk("R10", {28'b0, word_q}, 32'h4);
    slip_req = 1'b0;
    repeat (4) tick_pat();

    // slip landing on a boundary (R11)
    for (int i = 0; i < 8; i++) begin
      if ((m + 2) % (2*W) == W-1) break;
      tick_pat();
    end
    raise_slip();
    tick_pat(); tick_pat(); tick_pat();
    chk("R11", {30'b0, word_vld, div4_en}, 32'h0);
    tick_pat();
    chk("R11", {30'b0, word_vld, div4_en}, 32'h3);
    slip_req = 1'b0;
    repeat (6) tick_pat();

    // wide mode (R7)
    do_reset(1'b0);
    mode8 = 1'b1;
    for (int f = 0; f < 2; f++) begin
      logic [7:0] fr;
      fr = (f == 0) ? 8'hA5 : 8'h3C;
      for (int k = 0; k < 8; k++) begin
        tick(fr[k]);
        if (k == 3) chk("R7", {30'b0, div4_en, word_vld}, 32'h2);
      end
      chk("R7", {28'b0, word_q}, {28'b0, fr[7:4]});
      chk("R7", {30'b0, word_vld, div8_en}, 32'h3);
    end
    mode8 = 1'b0;
    repeat (8) tick_pat();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule